// File: doc/BRIEF.md
# Multi-Channel Transfer Arbiter with Bus Ownership Control

This block chooses which of up to four transfer channels gets the shared system bus, and it runs the request/grant handshake with the bus owner. Each channel lane has a request line and a two-bit mode tag. When a lane is eligible and the bus is free, the arbiter raises a bus request. When the grant arrives, it latches the winning lane as a one-hot select and pulses a strobe once for each byte or word to be moved. The channel datapath reports the end of each unit, and the end of a burst or block, on the done inputs.

The mode of the winning lane sets when the bus is given back. Single-unit modes release it after every unit. Burst and block modes keep it until their last unit. They yield early, after the current unit, if a higher-priority lane or a higher-priority bus master asks for the bus. A configuration input picks one of two layouts. In the four-lane layout, lanes 0..3 have fixed priority in index order. In the two-channel layout, only the even lanes take part, and lane 0 has priority over lane 2. After a release, the bus request stays low for at least two cycles before any pending lane requests the bus again.

Top module: `dmaarb_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the arbiter returns to idle. After that edge `bus_req`, `act_sel` and `xfer_stb` are all 0.
- R2: In idle, if any lane is eligible at a clock edge, `bus_req` is 1 after that edge.
- R3: `bus_grant` is sampled while `bus_req` is high and no lane is active. At that edge the lowest-index eligible lane wins. After the edge `act_sel` is that lane's one-hot bit and `xfer_stb` is 1 for one cycle.
- R4: With `cfg_full`=1 (two-channel layout), requests on odd lanes are ignored. They raise no `bus_req` and never win. Lane 0 beats lane 2.
- R5: While a lane is active, `act_sel` does not change until the bus is released, whatever the other request lines do.
- R6: Mode code 2'b00 or 2'b11 (single unit) on the active lane: the edge that samples `unit_done`=1 releases the bus. After it `bus_req`=0 and `act_sel`=0.
- R7: Mode code 2'b01 (burst) or 2'b10 (block): `unit_done`=1 with `block_done`=0 and no higher-priority demand gives a new `xfer_stb` pulse on the next cycle, and `bus_req` stays 1.
- R8: In burst or block mode, `unit_done`=1 together with `block_done`=1 releases the bus.
- R9: In burst or block mode, `unit_done`=1 while a lower-index eligible lane or `hp_master_req` is present releases the bus. A request on a higher-index lane does not.
- R10: After a release, `bus_req` stays 0 for at least two cycles. It then rises again if any lane is still eligible.
- R11: `cfg_full` takes effect only while the bus is not owned (release and idle cycles). A change during ownership does not alter eligibility or preemption until the bus is released.
- R12: `xfer_stb` is high only while `bus_req` is high and exactly one `act_sel` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_full | input | 1 | 1 = two-channel layout (even lanes only), 0 = four-lane layout |
| ch_req | input | NUM_LANES | Per-lane transfer request |
| ch_mode | input | 2*NUM_LANES | Per-lane mode code, lane i at bits [2i+1:2i] |
| bus_grant | input | 1 | Bus grant from the system bus owner |
| hp_master_req | input | 1 | Bus request from a higher-priority master |
| unit_done | input | 1 | Datapath finished the current byte or word |
| block_done | input | 1 | The finished unit was the last of a burst or block |
| bus_req | output | 1 | Bus request to the system bus owner |
| act_sel | output | NUM_LANES | One-hot active lane select |
| xfer_stb | output | 1 | One-cycle pulse starting one unit transfer |

## Verification
Assertions check on every cycle that the select is one-hot and unchanged while owned, and that strobes occur only under ownership. They also check the low gap of `bus_req` after each release, the idle-to-request step, and the continue or release decision taken at each `unit_done` for every mode. Only the bench scenarios can show that the right lane wins at grant time when requests change beforehand, and that odd lanes are ignored in the two-channel layout. The same holds for a layout change made during ownership, which must have no effect on a running burst, and for requests re-issued in priority order after each release.

// File: rtl/dmaarb_pkg.sv
// Shared types and mode decoding for the transfer arbiter.
// Assumes a two-bit mode code per lane.
package dmaarb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_START = 3'd2,
        ST_WAIT  = 3'd3,
        ST_REL   = 3'd4
    } arb_state_t;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 2'b00;
    localparam logic [MODE_W-1:0] MODE_BURST  = 2'b01;
    localparam logic [MODE_W-1:0] MODE_BLOCK  = 2'b10;

    // True when the mode keeps the bus across units.
    function automatic logic mode_holds(input logic [MODE_W-1:0] m);
        return (m == MODE_BURST) || (m == MODE_BLOCK);
    endfunction

endpackage

// File: rtl/dmaarb_elig.sv
// Eligibility mask: passes lane requests that are valid in the latched
// layout. In the two-channel layout only even lanes may take part.
// Assumes NUM_LANES is even.
module dmaarb_elig #(
    parameter int NUM_LANES = 4
) (
    input  logic                 full_q,
    input  logic [NUM_LANES-1:0] req,
    output logic [NUM_LANES-1:0] elig
);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        if ((i % 2) == 0) begin : g_even
            // Even lanes are valid in both layouts.
            assign elig[i] = req[i];
        end else begin : g_odd
            // Odd lanes are masked in the two-channel layout.
            assign elig[i] = req[i] & ~full_q;
        end
    end

endmodule

// File: rtl/dmaarb_prio.sv
// Fixed-priority picker: the lowest index wins. Also reports whether any
// eligible lane ranks above the currently active lane.
// Assumes act is one-hot or zero.
module dmaarb_prio #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] elig,
    input  logic [NUM_LANES-1:0] act,
    output logic [NUM_LANES-1:0] win,
    output logic                 higher
);

    // Lowest-index eligible lane becomes the one-hot winner.
    always_comb begin
        logic found;
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (elig[i] && !found) begin
                win[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Flags an eligible lane with an index below the active lane.
    always_comb begin
        logic seen;
        higher = 1'b0;
        seen   = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (act[i] && seen) begin
                higher = 1'b1;
            end
            seen = seen | elig[i];
        end
    end

    a_r3_win_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win) && ((win == '0) == (elig == '0)));

    a_r3_win_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (win & ~elig) == '0);

endmodule

// File: rtl/dmaarb_fsm.sv
// Ownership state machine: requests the bus, latches the winner at grant,
// issues unit strobes and decides release per the latched mode.
// Assumes unit_done is only meaningful after a strobe.
module dmaarb_fsm
    import dmaarb_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_full,
    input  logic [NUM_LANES-1:0]        elig,
    input  logic [NUM_LANES-1:0]        win,
    input  logic                        higher,
    input  logic [MODE_W*NUM_LANES-1:0] ch_mode,
    input  logic                        bus_grant,
    input  logic                        hp_master_req,
    input  logic                        unit_done,
    input  logic                        block_done,
    output logic                        full_q,
    output logic [NUM_LANES-1:0]        act_q,
    output logic                        bus_req,
    output logic [NUM_LANES-1:0]        act_sel,
    output logic                        xfer_stb
);

    arb_state_t        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] win_mode;
    logic              any_elig;
    logic              yield_now;

    assign any_elig  = |elig;
    assign yield_now = block_done | higher | hp_master_req;

    // Selects the mode code of the winning lane.
    always_comb begin
        win_mode = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (win[i]) begin
                win_mode = ch_mode[MODE_W*i +: MODE_W];
            end
        end
    end

    // Next-state decision for bus ownership.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_elig) state_d = ST_REQ;
            ST_REQ:   if (bus_grant) state_d = any_elig ? ST_START : ST_REL;
            ST_START: state_d = ST_WAIT;
            ST_WAIT: begin
                if (unit_done) begin
                    if (!mode_holds(mode_q) || yield_now) state_d = ST_REL;
                    else                                  state_d = ST_START;
                end
            end
            ST_REL:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latches winner and its mode at grant; clears select on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            mode_q <= MODE_SINGLE;
        end else if (state_q == ST_REQ && bus_grant && any_elig) begin
            act_q  <= win;
            mode_q <= win_mode;
        end else if (state_q == ST_REL) begin
            act_q  <= '0;
        end
    end

    // Samples the layout input only while the bus is not owned.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b0;
        else if (state_q == ST_IDLE || state_q == ST_REL) full_q <= cfg_full;
    end

    // Output decode from state.
    assign bus_req  = (state_q == ST_REQ) || (state_q == ST_START) || (state_q == ST_WAIT);
    assign act_sel  = (state_q == ST_START || state_q == ST_WAIT) ? act_q : '0;
    assign xfer_stb = (state_q == ST_START);

    a_r2_idle_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && any_elig) |=> bus_req);

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_sel));

    a_r5_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != '0) |=> (act_sel == '0 || act_sel == $past(act_sel)));

    a_r6_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && unit_done && !mode_holds(mode_q)) |=> (!bus_req && act_sel == '0));

    a_r7_burst_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && unit_done && mode_holds(mode_q) && !yield_now) |=> (xfer_stb && bus_req));

    a_r8_end_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && unit_done && block_done) |=> !bus_req);

    a_r9_yield_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && unit_done && (higher || hp_master_req)) |=> !bus_req);

    a_r10_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |=> !bus_req);

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(full_q));

    a_r12_stb_owned: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> (bus_req && $onehot(act_sel)));

endmodule

// File: rtl/dmaarb_top.sv
// Top of the transfer arbiter: eligibility mask, fixed-priority picker and
// ownership state machine. Assumes NUM_LANES is even and at least 2.
module dmaarb_top
    import dmaarb_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_full,
    input  logic [NUM_LANES-1:0]        ch_req,
    input  logic [MODE_W*NUM_LANES-1:0] ch_mode,
    input  logic                        bus_grant,
    input  logic                        hp_master_req,
    input  logic                        unit_done,
    input  logic                        block_done,
    output logic                        bus_req,
    output logic [NUM_LANES-1:0]        act_sel,
    output logic                        xfer_stb
);

    logic                 full_q;
    logic [NUM_LANES-1:0] elig;
    logic [NUM_LANES-1:0] win;
    logic [NUM_LANES-1:0] act_q;
    logic                 higher;

    dmaarb_elig #(.NUM_LANES(NUM_LANES)) u_elig (
        .full_q (full_q),
        .req    (ch_req),
        .elig   (elig)
    );

    dmaarb_prio #(.NUM_LANES(NUM_LANES)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig   (elig),
        .act    (act_q),
        .win    (win),
        .higher (higher)
    );

    dmaarb_fsm #(.NUM_LANES(NUM_LANES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_full      (cfg_full),
        .elig          (elig),
        .win           (win),
        .higher        (higher),
        .ch_mode       (ch_mode),
        .bus_grant     (bus_grant),
        .hp_master_req (hp_master_req),
        .unit_done     (unit_done),
        .block_done    (block_done),
        .full_q        (full_q),
        .act_q         (act_q),
        .bus_req       (bus_req),
        .act_sel       (act_sel),
        .xfer_stb      (xfer_stb)
    );

    a_r4_odd_masked: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> (act_sel[1] == 1'b0 && act_sel[NUM_LANES-1] == 1'b0));

endmodule

// File: tb/dmaarb_top_test.sv
// Scoreboard bench: the driver pushes the expected select for each strobe,
// and the monitor pops and compares whenever a strobe appears.
module dmaarb_top_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_full = 1'b0;
    logic [N-1:0] ch_req = '0;
    logic [2*N-1:0] ch_mode = '0;
    logic         bus_grant = 1'b0;
    logic         hp_master_req = 1'b0;
    logic         unit_done = 1'b0;
    logic         block_done = 1'b0;
    logic         bus_req;
    logic [N-1:0] act_sel;
    logic         xfer_stb;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] expq[$];

    dmaarb_top #(.NUM_LANES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_full(cfg_full), .ch_req(ch_req),
        .ch_mode(ch_mode), .bus_grant(bus_grant), .hp_master_req(hp_master_req),
        .unit_done(unit_done), .block_done(block_done), .bus_req(bus_req),
        .act_sel(act_sel), .xfer_stb(xfer_stb)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_unit(input logic [N-1:0] sel);
        expq.push_back(sel);
    endtask

    task automatic do_unit(input logic last);
        unit_done  = 1'b1;
        block_done = last;
        tick();
        unit_done  = 1'b0;
        block_done = 1'b0;
    endtask

    task automatic set_mode(input int lane, input logic [1:0] m);
        ch_mode[2*lane +: 2] = m;
    endtask

    // Monitor: compares every strobe against the scoreboard queue (R3).
    always @(negedge clk) begin
        if (rst_n && xfer_stb) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R3 strobe actual=%0h expected=none", act_sel);
            end else begin
                logic [N-1:0] e;
                e = expq.pop_front();
                if (act_sel !== e) begin
                    errors++;
                    $display("FAIL R3 strobe select actual=%0h expected=%0h", act_sel, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(); tick(); tick();
        chk("R1 bus_req", bus_req, 0);
        chk("R1 act_sel", act_sel, 0);
        chk("R1 xfer_stb", xfer_stb, 0);
        rst_n = 1'b1;
        tick();

        // Four-lane layout, single mode: priority, hold, release, re-request
        ch_req = 4'b1100;
        tick();
        chk("R2 bus_req raised", bus_req, 1);
        ch_req = 4'b1110;
        expect_unit(4'b0010);
        bus_grant = 1'b1;
        tick();
        chk("R3 winner at grant", act_sel, 4'b0010);
        bus_grant = 1'b0;
        ch_req = 4'b1111;
        tick();
        chk("R5 select held", act_sel, 4'b0010);
        do_unit(1'b0);
        chk("R6 released bus_req", bus_req, 0);
        chk("R6 released act_sel", act_sel, 0);
        tick();
        chk("R10 gap second cycle", bus_req, 0);
        tick();
        chk("R10 re-request", bus_req, 1);
        expect_unit(4'b0001);
        bus_grant = 1'b1;
        tick();
        chk("R3 lane0 highest", act_sel, 4'b0001);
        bus_grant = 1'b0;
        ch_req = 4'b0000;
        tick();
        do_unit(1'b0);
        tick(); tick();
        chk("R2 stays idle", bus_req, 0);

        // Burst on lane 1: continue, lower lane ignored, end releases
        set_mode(1, 2'b01);
        ch_req = 4'b0010;
        tick();
        expect_unit(4'b0010);
        bus_grant = 1'b1;
        tick();
        bus_grant = 1'b0;
        ch_req = 4'b1010;
        tick();
        expect_unit(4'b0010);
        do_unit(1'b0);
        chk("R7 burst holds bus", bus_req, 1);
        chk("R9 lower lane no yield", xfer_stb, 1);
        tick();
        do_unit(1'b1);
        chk("R8 burst end releases", bus_req, 0);
        ch_req = 4'b0000;
        set_mode(1, 2'b00);
        tick(); tick();

        // Block on lane 3 yields to lane 0
        set_mode(3, 2'b10);
        ch_req = 4'b1000;
        tick();
        expect_unit(4'b1000);
        bus_grant = 1'b1;
        tick();
        bus_grant = 1'b0;
        tick();
        ch_req = 4'b1001;
        tick();
        chk("R5 no preempt mid-unit", act_sel, 4'b1000);
        do_unit(1'b0);
        chk("R9 higher lane yield", bus_req, 0);
        ch_req = 4'b0001;
        tick();
        tick();
        expect_unit(4'b0001);
        bus_grant = 1'b1;
        tick();
        chk("R10 re-grant to lane0", act_sel, 4'b0001);
        bus_grant = 1'b0;
        ch_req = 4'b0000;
        tick();
        do_unit(1'b0);
        tick(); tick();

        // Burst on lane 0 yields to higher-priority master
        set_mode(0, 2'b01);
        ch_req = 4'b0001;
        tick();
        expect_unit(4'b0001);
        bus_grant = 1'b1;
        tick();
        bus_grant = 1'b0;
        tick();
        hp_master_req = 1'b1;
        do_unit(1'b0);
        chk("R9 master yield", bus_req, 0);
        hp_master_req = 1'b0;
        ch_req = 4'b0000;
        set_mode(0, 2'b00);
        tick(); tick();

        // Two-channel layout
        cfg_full = 1'b1;
        tick();
        ch_req = 4'b1010;
        tick(); tick();
        chk("R4 odd lanes ignored", bus_req, 0);
        ch_req = 4'b0101;
        tick();
        chk("R4 even lane requests", bus_req, 1);
        expect_unit(4'b0001);
        bus_grant = 1'b1;
        tick();
        chk("R4 lane0 beats lane2", act_sel, 4'b0001);
        bus_grant = 1'b0;
        ch_req = 4'b0100;
        tick();
        do_unit(1'b0);
        set_mode(2, 2'b01);
        tick(); tick();
        ch_req = 4'b0110;
        expect_unit(4'b0100);
        bus_grant = 1'b1;
        tick();
        chk("R4 lane2 wins", act_sel, 4'b0100);
        bus_grant = 1'b0;
        tick();
        cfg_full = 1'b0;
        expect_unit(4'b0100);
        do_unit(1'b0);
        chk("R11 layout frozen", bus_req, 1);
        chk("R11 select kept", act_sel, 4'b0100);
        tick();
        ch_req = 4'b0111;
        do_unit(1'b0);
        chk("R9 full-layout yield", bus_req, 0);
        ch_req = 4'b0010;
        set_mode(1, 2'b00);
        tick();
        tick();
        chk("R11 new layout taken", bus_req, 1);
        expect_unit(4'b0010);
        bus_grant = 1'b1;
        tick();
        chk("R11 odd lane now wins", act_sel, 4'b0010);
        bus_grant = 1'b0;
        ch_req = 4'b0000;
        tick();
        do_unit(1'b0);
        tick(); tick();

        chk("R3 scoreboard drained", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule